// File: doc/BRIEF.md
# FM Read-Stream Clock/Data Separator

This block takes a frequency-modulated serial read stream, of the kind returned by tape and disk read channels, and splits it into a stream of clock strobes and a stream of recovered data bits. Every bit cell opens with a clock pulse. The block then opens a data window. Any read pulse that lands inside this window counts as data. Once the window has timed out, the rest of the cell belongs to the clock window, where the next pulse is expected.

The data window has two lengths, both set at run time in clock cycles. The short length is used after a cell that held a data pulse. The long length is used after a cell that did not. Each length has its own timer. The timer that is not selected stays in reset. A separated data strobe lasts a fixed number of cycles, and the window cannot close while that strobe is in progress. When a window closes, the cell's bit is presented with a one-cycle valid strobe. That bit also selects the window length for the following cell.

Top module: `fm_data_separator`

## Requirements
- R1: After reset no strobe is asserted, `bit_out` is 0, the clock window is open, and the recorded previous bit is 0, so the first data window uses the long length.
- R2: A read pulse while no data window is open asserts `sep_clk` in that same cycle (cycle 0). A data window then covers cycles 1 through L, where L is the selected length.
- R3: L is the short length when the previous cell's recovered bit was 1 and the long length when it was 0.
- R4: A read pulse inside an open data window, at cycle d, drives `sep_data` high for exactly PULSE_CYCLES cycles, d+1 through d+PULSE_CYCLES, and marks the cell as holding data.
- R5: The window closes in cycle c. In cycle c+1 `bit_valid` is high for exactly one cycle, and `bit_out` is 1 if the cell held a data pulse and 0 otherwise.
- R6: While a separated data strobe is in progress the window stays open. If d+PULSE_CYCLES >= L, the close cycle is c = d+PULSE_CYCLES+1; otherwise c = L.
- R7: The clock window is open exactly when no data window is open. A read pulse there is always classed as clock and never as data, and `sep_clk` and `sep_data` are never high together.
- R8: The timer for the length not selected by the previous bit is held idle, so at most one window timer runs at a time.
- R9: A programmed length of 0 acts as a length of 1.
- R10: Each separated clock clears the data mark, so a cell with no data pulse yields 0 even directly after a cell that yielded 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_pulse | input | 1 | One-cycle pulse from the read channel |
| short_len | input | LEN_W | Data-window length after a 1 cell, in cycles |
| long_len | input | LEN_W | Data-window length after a 0 cell, in cycles |
| sep_clk | output | 1 | Separated clock strobe, same cycle as the read pulse |
| sep_data | output | 1 | Separated data strobe, PULSE_CYCLES cycles long |
| bit_out | output | 1 | Recovered bit of the last closed cell |
| bit_valid | output | 1 | One-cycle strobe marking a new `bit_out` |

## Verification
The stream mixes cells with and without data. This shows whether the window length really follows the previous bit, because the close cycle moves between the short and long values. Data pulses are placed early in the window, in its last cycle and one cycle before its end, which separates a plain timeout from a close held back by a running data strobe. Cells follow each other both with an idle cycle in between and with the next clock pulse in the very cycle the bit is delivered, which shows that the clock window reopens on time. Zero lengths and a reset in the middle of a window cover the boundary cases.

// File: rtl/fmsep_pkg.sv
package fmsep_pkg;

  // which timer a cell uses: index 1 is the short window, index 0 the long
  typedef enum logic {
    SEL_LONG  = 1'b0,
    SEL_SHORT = 1'b1
  } win_sel_e;

  // a programmed length of zero still gives one window cycle
  function automatic int unsigned eff_len(input int unsigned raw);
    return (raw == 0) ? 1 : raw;
  endfunction

  // close cycle of a cell, counted from its clock pulse at cycle 0
  function automatic int unsigned close_cycle(input int unsigned len,
                                              input int unsigned hit_at,
                                              input int unsigned stretch);
    if (hit_at != 0 && hit_at + stretch >= len) return hit_at + stretch + 1;
    return len;
  endfunction

endpackage

// File: rtl/fmsep_timer.sv
module fmsep_timer #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold_clr,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  input  logic             extend,
  output logic             running,
  output logic             finish
);
  import fmsep_pkg::*;

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [LEN_W-1:0] cnt;
  logic             run_q;
  logic [LEN_W-1:0] load_val;

  assign load_val = LEN_W'(eff_len(int'(len)));
  assign running  = run_q;
  assign finish   = run_q && (cnt == ONE) && !extend;

  always_ff @(posedge clk) begin
    if (!rst_n || hold_clr) begin
      run_q <= 1'b0;
      cnt   <= '0;
    end else if (start && !run_q) begin
      run_q <= 1'b1;
      cnt   <= load_val;
    end else if (run_q) begin
      if (cnt > ONE) cnt <= cnt - ONE;
      else if (!extend) run_q <= 1'b0;
    end
  end

  // R8: a timer held in reset is idle in the next cycle
  assert_held_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_clr |=> !running);

  // R6: while extended on its last count the timer keeps running
  assert_extend_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (running && extend && !hold_clr) |=> running);

endmodule

// File: rtl/fmsep_stretch.sv
module fmsep_stretch #(
  parameter int PULSE_CYCLES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic active
);
  localparam int CW = $clog2(PULSE_CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(PULSE_CYCLES);

  logic [CW-1:0] left;

  assign active = (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)           left <= '0;
    else if (trig)        left <= LOAD;
    else if (left != '0)  left <= left - CW'(1);
  end

  // R4: a trigger always produces an active strobe next cycle
  assert_trig_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> active);

endmodule

// File: rtl/fmsep_cell.sv
module fmsep_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic clk_hit,
  input  logic data_hit,
  input  logic win_close,
  output logic prev_bit,
  output logic bit_out,
  output logic bit_valid
);
  logic mark;
  logic cell_bit;

  assign cell_bit = mark || data_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mark      <= 1'b0;
      prev_bit  <= 1'b0;
      bit_out   <= 1'b0;
      bit_valid <= 1'b0;
    end else begin
      if (clk_hit)       mark <= 1'b0;
      else if (data_hit) mark <= 1'b1;
      bit_valid <= win_close;
      if (win_close) begin
        bit_out  <= cell_bit;
        prev_bit <= cell_bit;
      end
    end
  end

  // R5: the valid strobe lasts one cycle
  assert_single_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bit_valid |=> !bit_valid);

  // R10: a separated clock leaves the cell unmarked
  assert_clk_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_hit && !win_close) |=> !mark);

endmodule

// File: rtl/fm_data_separator.sv
module fm_data_separator #(
  parameter int LEN_W        = 8,
  parameter int PULSE_CYCLES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_pulse,
  input  logic [LEN_W-1:0] short_len,
  input  logic [LEN_W-1:0] long_len,
  output logic             sep_clk,
  output logic             sep_data,
  output logic             bit_out,
  output logic             bit_valid
);
  import fmsep_pkg::*;

  localparam int N_TIMERS = 2;

  logic [N_TIMERS-1:0] tmr_running;
  logic [N_TIMERS-1:0] tmr_finish;
  logic                win_open;
  logic                clk_win;
  logic                data_hit;
  logic                data_busy;
  logic                win_close;
  logic                prev_bit;

  assign win_open  = |tmr_running;
  assign clk_win   = !win_open;
  assign sep_clk   = rd_pulse && clk_win;
  assign data_hit  = rd_pulse && win_open;
  assign win_close = |tmr_finish;
  assign sep_data  = data_busy;

  for (genvar g = 0; g < N_TIMERS; g++) begin : g_tmr
    logic sel_me;
    assign sel_me = (prev_bit == 1'(g));
    fmsep_timer #(.LEN_W(LEN_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (!sel_me),
      .start    (sep_clk && sel_me),
      .len      ((g == int'(SEL_SHORT)) ? short_len : long_len),
      .extend   (data_busy || data_hit),
      .running  (tmr_running[g]),
      .finish   (tmr_finish[g])
    );
  end

  fmsep_stretch #(.PULSE_CYCLES(PULSE_CYCLES)) u_stretch (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig   (data_hit),
    .active (data_busy)
  );

  fmsep_cell u_cell (
    .clk       (clk),
    .rst_n     (rst_n),
    .clk_hit   (sep_clk),
    .data_hit  (data_hit),
    .win_close (win_close),
    .prev_bit  (prev_bit),
    .bit_out   (bit_out),
    .bit_valid (bit_valid)
  );

  // R2: a separated clock opens a data window in the next cycle
  assert_clk_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sep_clk |=> win_open);

  // R7: clock and data strobes are exclusive
  assert_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(sep_clk && sep_data));

  // R6: the window is open for the whole data strobe
  assert_hold_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sep_data |-> win_open);

  // R8: never two timers at once
  assert_one_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tmr_running));

  // R5: the bit arrives in the cycle after the window closed
  assert_bit_after_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_open) |-> bit_valid);

  // R3: the running timer matches the previous bit
  assert_sel_match_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_running[int'(SEL_SHORT)] |-> prev_bit);

endmodule

// File: tb/fm_data_separator_test.sv
module fm_data_separator_test;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam int P          = 2;
  localparam int N_CELLS    = 8;
  // data offset in the cell (0 = no data pulse), and whether the next
  // cell's clock pulse lands in the cycle the bit is delivered
  localparam int CELL_OFF   [N_CELLS] = '{0, 2, 3, 1, 0, 6, 2, 0};
  localparam bit CELL_CHAIN [N_CELLS] = '{0, 1, 0, 1, 0, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd_pulse = 1'b0;
  logic [LEN_W-1:0] short_len = 8'd3;
  logic [LEN_W-1:0] long_len  = 8'd6;
  logic sep_clk, sep_data, bit_out, bit_valid;

  int n_tests = 0;
  int n_fail  = 0;
  bit prev    = 1'b0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fm_data_separator #(.LEN_W(LEN_W), .PULSE_CYCLES(P)) uut (
    .clk(clk), .rst_n(rst_n), .rd_pulse(rd_pulse),
    .short_len(short_len), .long_len(long_len),
    .sep_clk(sep_clk), .sep_data(sep_data),
    .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int len_of(input logic [LEN_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  // one bit cell; cycle 0 is the clock pulse, c the close cycle
  task automatic run_cell(input int d, input bit started, input bit chain,
                          input string req);
    int L, c, nsep, bad_clk, bad_valid;
    bit exp_bit, got_bit;
    L = prev ? len_of(short_len) : len_of(long_len);
    c = (d != 0 && d + P >= L) ? d + P + 1 : L;
    exp_bit = (d != 0);
    if (!started) begin
      @(negedge clk); rd_pulse = 1'b1; #1;
      check(sep_clk === 1'b1, "R2", {req, " clock strobe"}, int'(sep_clk), 1);
    end
    nsep = 0; bad_clk = 0; bad_valid = 0; got_bit = 1'b0;
    for (int i = 1; i <= c + 1; i++) begin
      @(negedge clk);
      rd_pulse = (i == d) || (chain && i == c + 1);
      #1;
      if (sep_clk !== (chain && i == c + 1)) bad_clk++;
      if (sep_data === 1'b1) nsep++;
      if (bit_valid !== (i == c + 1)) bad_valid++;
      if (i == c + 1) got_bit = bit_out;
    end
    check(bad_clk == 0, "R7", {req, " clock strobe misplaced"}, bad_clk, 0);
    check(bad_valid == 0, "R6", {req, " close timing (R3 R8 length)"}, bad_valid, 0);
    check(nsep == (exp_bit ? P : 0), "R4", {req, " data strobe width"}, nsep,
          exp_bit ? P : 0);
    check(got_bit == exp_bit, "R5", {req, " recovered bit (R10)"}, int'(got_bit),
          int'(exp_bit));
    prev = exp_bit;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit started;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check(sep_clk === 1'b0 && sep_data === 1'b0, "R1", "idle strobes",
          int'(sep_clk | sep_data), 0);
    check(bit_valid === 1'b0 && bit_out === 1'b0, "R1", "idle bit",
          int'(bit_valid | bit_out), 0);

    // table walk: first cell uses the long window (R1 R3)
    started = 1'b0;
    for (int k = 0; k < N_CELLS; k++) begin
      run_cell(CELL_OFF[k], started, CELL_CHAIN[k], $sformatf("cell%0d", k));
      started = CELL_CHAIN[k];
    end

    // R9: zero lengths behave as one cycle
    @(negedge clk); short_len = 8'd0; long_len = 8'd0; rd_pulse = 1'b0;
    run_cell(0, 1'b0, 1'b0, "R9 zero-long empty");
    run_cell(1, 1'b0, 1'b0, "R9 zero-long data");
    run_cell(0, 1'b0, 1'b0, "R9 zero-short empty");

    // reset in the middle of a window
    @(negedge clk); short_len = 8'd3; long_len = 8'd6;
    rd_pulse = 1'b1;
    @(negedge clk); rd_pulse = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    prev = 1'b0;
    @(negedge clk); rd_pulse = 1'b1; #1;
    check(sep_clk === 1'b1, "R1", "clock window open after reset", int'(sep_clk), 1);
    @(negedge clk); rd_pulse = 1'b1; #1;
    check(sep_clk === 1'b0 && sep_data === 1'b0, "R7", "pulse in window is data",
          int'(sep_clk), 0);
    @(negedge clk); rd_pulse = 1'b0; #1;
    check(sep_data === 1'b1, "R4", "data strobe after reset", int'(sep_data), 1);
    repeat (8) @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule